// File: doc/BRIEF.md
# Display Field Status Tracker

This block follows the field sequence of an interlaced display and produces the vertical blanking flag that a timing-word generator places in its start and end of active video words. Each picture is shown as either two fields or, under three-field pulldown, three fields. The block latches the picture's first-field parity and pulldown choice when that picture's first field starts. From them it derives a small status byte that host software reads.

The vertical flag falls when a field starts and stays low through the active lines. It rises once the active region has ended and a programmable number of further lines has passed. When that number is nonzero, odd fields wait one line longer. The delay nibble is host-writable, and a new value takes effect only at the next field start.

Top module: `field_status_tracker`

## Requirements
- R1: After reset, status_o reads 8'h0A and vflag_o is 0. Field bits: [7:4] delay, [3] odd-first, [2] last field, [1] current field odd, [0] end-of-field event.
- R2: With an active delay of 0, vflag_o goes to 1 in the cycle after the first line_stb_i that follows act_end_i, in both odd and even fields.
- R3: With an active delay D of 1 or more, vflag_o goes to 1 in the cycle after line strobe number D+I+1 counted from act_end_i. I is 1 when the current field is odd and 0 when it is even. Before that strobe, vflag_o stays 0.
- R4: vflag_o is 0 in the cycle after fld_start_i and stays 0 until the condition of R2 or R3 is met.
- R5: A write shows in status_o[7:4] in the cycle after reg_wr_i. The delay that line timing uses is the value present at the most recent fld_start_i, so a write made mid-field does not change that field's onset.
- R6: At a field start that begins a new picture, the block latches pic_odd_first_i and pic_pulldown_i. status_o[3] then equals the latched first-field parity (1 = odd first). The first field after reset begins a picture, and so does the field after a picture's last field.
- R7: status_o[2] is 1 while the second field of a two-field picture or the third field of a pulldown picture is shown, and 0 otherwise. The first two pulldown fields both count as first fields. Descriptor inputs at other field starts are ignored.
- R8: In the cycle after fld_start_i, status_o[1] equals the fld_odd_i value sampled at that strobe.
- R9: status_o[0] is set in the cycle after any fld_start_i that ends a displayed field, so not the first one after reset. It is cleared after a reg_rd_i in a cycle without fld_start_i. If both occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | One-cycle strobe per display line |
| act_end_i | input | 1 | One-cycle marker: active lines of this field have ended |
| fld_start_i | input | 1 | One-cycle strobe at the start of a field |
| fld_odd_i | input | 1 | Parity of the starting field (1 = odd), sampled with fld_start_i |
| pic_odd_first_i | input | 1 | Picture descriptor: first field is odd |
| pic_pulldown_i | input | 1 | Picture descriptor: shown as three fields |
| reg_wr_i | input | 1 | Write strobe for the delay nibble |
| reg_wdata_i | input | 4 | Delay value to write |
| reg_rd_i | input | 1 | Status read strobe (clears the event bit) |
| status_o | output | 8 | Status byte |
| vflag_o | output | 1 | Vertical blanking flag |

## Verification
Every result comes from a register. Each one is due in the cycle after the strobe that causes it: vflag_o after the qualifying line strobe or after a field start, the status bits after a field start, a write or a read. The bench drives each strobe for exactly one cycle, starting at a falling edge. It samples at the next falling edge, which is one rising edge later. For the delayed onset, the bench counts strobes one at a time and checks vflag_o after each one, so an onset one line early or one line late is caught. Sequencing checks step through two-field and pulldown pictures field by field.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam int unsigned DLY_W = 4;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic             odd_first;
    logic             last_fld;
    logic             cur_odd;
    logic             eof;
  } status_t;
endpackage

// File: rtl/fst_seq.sv
module fst_seq #(
  parameter int unsigned MAX_FLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fld_start_i,
  input  logic fld_odd_i,
  input  logic pic_odd_first_i,
  input  logic pic_pulldown_i,
  output logic odd_first_o,
  output logic last_fld_o,
  output logic cur_odd_o,
  output logic fld_end_o
);
  localparam int unsigned IDX_W = $clog2(MAX_FLD);

  logic             started_q;
  logic             pull_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic             at_last;
  logic             new_pic;

  assign last_idx = pull_q ? IDX_W'(MAX_FLD - 1) : IDX_W'(MAX_FLD - 2);
  assign at_last  = (idx_q == last_idx);
  assign new_pic  = !started_q || at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      pull_q      <= 1'b0;
      idx_q       <= '0;
      odd_first_o <= 1'b1;
      cur_odd_o   <= 1'b1;
    end else if (fld_start_i) begin
      started_q <= 1'b1;
      cur_odd_o <= fld_odd_i;
      if (new_pic) begin
        odd_first_o <= pic_odd_first_i;
        pull_q      <= pic_pulldown_i;
        idx_q       <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign last_fld_o = started_q && at_last;
  assign fld_end_o  = fld_start_i && started_q;
endmodule

// File: rtl/fst_vflag.sv
module fst_vflag #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_stb_i,
  input  logic             act_end_i,
  input  logic             fld_start_i,
  input  logic             cur_odd_i,
  input  logic [DLY_W-1:0] dly_shadow_i,
  output logic             vflag_o
);
  localparam int unsigned CNT_W = DLY_W + 1;

  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] target;
  logic             armed_q;

  // odd fields wait one extra line only when a delay is programmed
  always_comb begin
    if (dly_q == '0) target = CNT_W'(1);
    else             target = CNT_W'(dly_q) + CNT_W'(cur_odd_i) + CNT_W'(1);
  end

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vflag_o <= 1'b0;
    end else if (fld_start_i) begin
      dly_q   <= dly_shadow_i;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vflag_o <= 1'b0;
    end else if (act_end_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (armed_q && line_stb_i) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == target) begin
        vflag_o <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fst_regs.sv
module fst_regs #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [DLY_W-1:0] reg_wdata_i,
  input  logic             reg_rd_i,
  input  logic             fld_end_i,
  output logic [DLY_W-1:0] dly_shadow_o,
  output logic             eof_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_shadow_o <= '0;
      eof_o        <= 1'b0;
    end else begin
      if (reg_wr_i) dly_shadow_o <= reg_wdata_i;
      if (fld_end_i)     eof_o <= 1'b1;
      else if (reg_rd_i) eof_o <= 1'b0;
    end
  end
endmodule

// File: rtl/field_status_tracker.sv
module field_status_tracker
  import fst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_stb_i,
  input  logic             act_end_i,
  input  logic             fld_start_i,
  input  logic             fld_odd_i,
  input  logic             pic_odd_first_i,
  input  logic             pic_pulldown_i,
  input  logic             reg_wr_i,
  input  logic [DLY_W-1:0] reg_wdata_i,
  input  logic             reg_rd_i,
  output logic [7:0]       status_o,
  output logic             vflag_o
);
  logic             odd_first, last_fld, cur_odd, fld_end, eof;
  logic [DLY_W-1:0] dly_shadow;
  status_t          st;

  fst_seq #(.MAX_FLD(3)) u_seq (
    .clk_i, .rst_ni, .fld_start_i, .fld_odd_i, .pic_odd_first_i, .pic_pulldown_i,
    .odd_first_o(odd_first), .last_fld_o(last_fld), .cur_odd_o(cur_odd),
    .fld_end_o(fld_end)
  );

  fst_vflag #(.DLY_W(DLY_W)) u_vflag (
    .clk_i, .rst_ni, .line_stb_i, .act_end_i, .fld_start_i,
    .cur_odd_i(cur_odd), .dly_shadow_i(dly_shadow), .vflag_o
  );

  fst_regs #(.DLY_W(DLY_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_wdata_i, .reg_rd_i,
    .fld_end_i(fld_end), .dly_shadow_o(dly_shadow), .eof_o(eof)
  );

  always_comb begin
    st.dly       = dly_shadow;
    st.odd_first = odd_first;
    st.last_fld  = last_fld;
    st.cur_odd   = cur_odd;
    st.eof       = eof;
  end

  assign status_o = st;
endmodule

// File: rtl/fst_chk.sv
module fst_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_stb_i,
  input logic       act_end_i,
  input logic       fld_start_i,
  input logic       fld_odd_i,
  input logic       reg_wr_i,
  input logic [3:0] reg_wdata_i,
  input logic       reg_rd_i,
  input logic [7:0] status_o,
  input logic       vflag_o
);
  p_rise_on_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vflag_o) |-> $past(line_stb_i));
  p_rise_not_at_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_end_i && !fld_start_i |=> !$rose(vflag_o));
  p_clr_at_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i |=> !vflag_o);
  p_dly_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> status_o[7:4] == $past(reg_wdata_i));
  p_odd_first_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fld_start_i |=> $stable(status_o[3:1]));
  p_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_start_i |=> status_o[1] == $past(fld_odd_i));
  p_eof_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && !fld_start_i |=> !status_o[0]);
endmodule

bind field_status_tracker fst_chk u_chk (
  .clk_i, .rst_ni, .line_stb_i, .act_end_i, .fld_start_i, .fld_odd_i,
  .reg_wr_i, .reg_wdata_i, .reg_rd_i, .status_o, .vflag_o
);

// File: tb/tb_field_status_tracker.sv
`timescale 1ns/1ps
module tb_field_status_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_stb_i = 1'b0, act_end_i = 1'b0, fld_start_i = 1'b0, fld_odd_i = 1'b0;
  logic       pic_odd_first_i = 1'b0, pic_pulldown_i = 1'b0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [3:0] reg_wdata_i = '0;
  logic [7:0] status_o;
  logic       vflag_o;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  field_status_tracker dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic fstart(input bit odd, input bit pf, input bit pd);
    fld_odd_i = odd; pic_odd_first_i = pf; pic_pulldown_i = pd; fld_start_i = 1'b1;
    @(negedge clk_i);
    fld_start_i = 1'b0;
  endtask

  task automatic line();
    line_stb_i = 1'b1;
    @(negedge clk_i);
    line_stb_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic aend();
    act_end_i = 1'b1;
    @(negedge clk_i);
    act_end_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] d);
    reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(status_o == 8'h0A, "R1 status", status_o, 8'h0A);
    chk(vflag_o == 1'b0, "R1 vflag", vflag_o, 0);
  endtask

  task automatic t_zero_delay();
    do_reset();
    for (int p = 0; p < 2; p++) begin
      fstart(p[0], 1'b1, 1'b0);
      chk(vflag_o == 1'b0, "R4 low after start", vflag_o, 0);
      aend();
      chk(vflag_o == 1'b0, "R2 low at end marker", vflag_o, 0);
      line();
      chk(vflag_o == 1'b1, "R2 first line", vflag_o, 1);
    end
  endtask

  task automatic onset(input bit odd, input int d, input string tag);
    int tgt;
    tgt = (d == 0) ? 1 : d + int'(odd) + 1;
    fstart(odd, 1'b1, 1'b0);
    chk(vflag_o == 1'b0, "R4 cleared", vflag_o, 0);
    aend();
    for (int k = 1; k <= tgt; k++) begin
      line();
      chk(vflag_o == (k == tgt), tag, vflag_o, int'(k == tgt));
    end
  endtask

  task automatic t_delay();
    do_reset();
    wr(4'd3);
    chk(status_o[7:4] == 4'd3, "R5 readback", status_o[7:4], 3);
    onset(1'b0, 3, "R3 even D=3");
    onset(1'b1, 3, "R3 odd D=3");
    wr(4'd1);
    onset(1'b1, 1, "R3 odd D=1");
    // mid-field write must not move this field's onset
    fstart(1'b0, 1'b1, 1'b0);
    wr(4'd5);
    chk(status_o[7:4] == 4'd5, "R5 readback mid", status_o[7:4], 5);
    aend();
    line();
    chk(vflag_o == 1'b0, "R5 old delay line1", vflag_o, 0);
    line();
    chk(vflag_o == 1'b1, "R5 old delay line2", vflag_o, 1);
    onset(1'b0, 5, "R5 new delay even");
  endtask

  task automatic t_pictures();
    do_reset();
    fstart(1'b1, 1'b0, 1'b0);
    chk(status_o[3] == 1'b0, "R6 even first", status_o[3], 0);
    chk(status_o[2] == 1'b0, "R7 field1 of 2", status_o[2], 0);
    chk(status_o[1] == 1'b1, "R8 parity odd", status_o[1], 1);
    fstart(1'b0, 1'b1, 1'b1);
    chk(status_o[3] == 1'b0, "R7 descriptor ignored", status_o[3], 0);
    chk(status_o[2] == 1'b1, "R7 field2 of 2", status_o[2], 1);
    chk(status_o[1] == 1'b0, "R8 parity even", status_o[1], 0);
    fstart(1'b1, 1'b1, 1'b1);
    chk(status_o[3] == 1'b1, "R6 odd first pulldown", status_o[3], 1);
    chk(status_o[2] == 1'b0, "R7 pulldown f1", status_o[2], 0);
    fstart(1'b0, 1'b0, 1'b0);
    chk(status_o[2] == 1'b0, "R7 pulldown f2 still first", status_o[2], 0);
    chk(status_o[3] == 1'b1, "R7 pulldown f2 ignored", status_o[3], 1);
    fstart(1'b1, 1'b0, 1'b0);
    chk(status_o[2] == 1'b1, "R7 pulldown f3", status_o[2], 1);
    fstart(1'b0, 1'b0, 1'b0);
    chk(status_o[3] == 1'b0, "R6 new picture", status_o[3], 0);
    chk(status_o[2] == 1'b0, "R7 new picture f1", status_o[2], 0);
  endtask

  task automatic t_eof();
    do_reset();
    fstart(1'b1, 1'b1, 1'b0);
    chk(status_o[0] == 1'b0, "R9 first start no event", status_o[0], 0);
    fstart(1'b0, 1'b1, 1'b0);
    chk(status_o[0] == 1'b1, "R9 event set", status_o[0], 1);
    reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
    chk(status_o[0] == 1'b0, "R9 cleared by read", status_o[0], 0);
    reg_rd_i = 1'b1;
    fstart(1'b1, 1'b1, 1'b0);
    reg_rd_i = 1'b0;
    chk(status_o[0] == 1'b1, "R9 set wins", status_o[0], 1);
  endtask

  initial begin
    t_reset();
    t_zero_delay();
    t_delay();
    t_pictures();
    t_eof();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule